// File: doc/BRIEF.md
# Exception Entry Sequencer for a 64-bit Status Model

This block carries out the state changes a 64-bit processor model makes when it takes an exception. The caller presents the current program counter, the current status word, the exception kind and the level that should handle it. It also presents that level's vector base and system-control word, and a flag that says whether memory tag checking is built into the core. On a one-cycle start pulse the block does four things. It picks the vector slot, saves the old program counter and status into the handling level's link and saved-status registers, builds the new status word field by field, and loads the program counter with the handler address.

Two handling levels are modelled. Each has its own link and saved-status register pair. The vector slot comes from comparing the current mode field with the requested target mode. A request for any target other than the two handler-stack modes is refused: the block flags an error and changes no state. The register file and the real pipeline sit outside the block.

Top module: `exc_entry_unit`

## Requirements
- R1: While reset is asserted and after it is released, the program counter, the status word, both link registers and both saved-status registers read zero, and `done_o` and `err_o` read 0.
- R2: The mode field is status bits [4:0]. Bit 4 is the 32-bit flag and bit 0 is the stack-select bit. The slot base is chosen as follows. When the mode field equals the target, the base is 0x200. When the mode field with bit 0 forced to 1 equals the target, the base is 0x000. Otherwise the base is 0x400 if bit 4 is 0, and 0x600 if bit 4 is 1.
- R3: The kind codes are 0 synchronous, 1 IRQ, 2 FIQ and 3 SError. The kind adds 0x80 times its code to the slot base. The new program counter is the vector base plus this offset, in full 64-bit arithmetic.
- R4: The new status copies N, Z, C and V (bits 31..28) and DIT (bit 24) from the old status. UAO (23), SS (21), IL (20) and BTYPE (11:10) become 0, as do all bits not named in R4 to R7.
- R5: TCO (bit 25) of the new status equals `tag_en_i`.
- R6: PAN (bit 22) of the new status keeps its old value, but it is 1 whenever system-control bit 23 is 0.
- R7: SSBS (bit 12) of the new status equals system-control bit 44. The mask bits D, A, I and F (bits 9..6) are all 1. Bits [4:0] equal the target mode.
- R8: The legal targets are 0x05 (level 1) and 0x09 (level 2). For a legal target, the chosen level's link register receives the old program counter and its saved-status register receives the old status. The other level's pair is left unchanged.
- R9: An illegal target mode makes `err_o` read 1 in the cycle that `done_o` reads 1. The program counter, the status word and all link and saved-status registers are left unchanged.
- R10: `done_o` reads 1 in the cycle after a start pulse and for that one cycle only. It reads 0 in every cycle that does not follow a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to take an exception |
| exc_kind_i | input | 2 | Exception kind: 0 sync, 1 IRQ, 2 FIQ, 3 SError |
| tgt_mode_i | input | 5 | Requested handler mode |
| cur_pc_i | input | 64 | Program counter at the faulting point |
| cur_psr_i | input | 32 | Status word at the faulting point |
| vbase_i | input | 64 | Vector base of the target level |
| sysctl_i | input | 64 | System-control word of the target level |
| tag_en_i | input | 1 | Memory tag checking present |
| done_o | output | 1 | Entry finished (one-cycle pulse) |
| err_o | output | 1 | Request refused because of an illegal target |
| pc_o | output | 64 | Modelled program counter |
| psr_o | output | 32 | Modelled status word |
| elr1_o | output | 64 | Level-1 link register |
| spsr1_o | output | 32 | Level-1 saved status |
| elr2_o | output | 64 | Level-2 link register |
| spsr2_o | output | 32 | Level-2 saved status |

## Verification
The bench sweeps all 32 mode-field values against both legal targets, four illegal targets and all four kinds, using random flags, control words and bases. Each of the four slots is reached, including the thread-stack case where only bit 0 differs. A selector that ignored the 32-bit flag would place 32-bit callers in the 64-bit lower slot, and a missing thread-stack case would send them to the lower slots. A builder that leaked old UAO, SS or BTYPE, or that lost the forced PAN, would show up in the status word. An illegal target that wrote state, or a level decode that was crossed, would corrupt the saved pairs, which the bench tracks from its own model.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN  = 64;
  localparam int PSR_W = 32;
  localparam int MODE_W = 5;
  localparam int KIND_W = 2;
  localparam int SLOT_SHIFT = 7;
  localparam int OFS_W = 2 + KIND_W + SLOT_SHIFT;

  typedef enum logic [KIND_W-1:0] {
    KIND_SYNC = 2'd0,
    KIND_IRQ  = 2'd1,
    KIND_FIQ  = 2'd2,
    KIND_SERR = 2'd3
  } exc_kind_e;

  typedef enum logic [1:0] {
    SLOT_CUR_THREAD = 2'd0,
    SLOT_CUR_HANDLR = 2'd1,
    SLOT_LOW_WIDE   = 2'd2,
    SLOT_LOW_NARROW = 2'd3
  } slot_e;

  localparam logic [MODE_W-1:0] MODE_LV1_H = 5'h05;
  localparam logic [MODE_W-1:0] MODE_LV2_H = 5'h09;

  localparam int B_N     = 31;
  localparam int B_Z     = 30;
  localparam int B_C     = 29;
  localparam int B_V     = 28;
  localparam int B_TCO   = 25;
  localparam int B_DIT   = 24;
  localparam int B_PAN   = 22;
  localparam int B_SSBS  = 12;
  localparam int B_DBG   = 9;
  localparam int B_SERRM = 8;
  localparam int B_IRQM  = 7;
  localparam int B_FIQM  = 6;
  localparam int B_NARROW = 4;

  localparam int SC_SPAN  = 23;
  localparam int SC_DSSBS = 44;
endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
  import exc_entry_pkg::*;
(
  input  logic [MODE_W-1:0] cur_mode_i,
  input  logic [MODE_W-1:0] tgt_mode_i,
  input  logic [KIND_W-1:0] kind_i,
  output logic [OFS_W-1:0]  offset_o
);
  slot_e slot;

  always_comb begin
    if (cur_mode_i == tgt_mode_i)
      slot = SLOT_CUR_HANDLR;
    else if ((cur_mode_i | {{(MODE_W-1){1'b0}}, 1'b1}) == tgt_mode_i)
      slot = SLOT_CUR_THREAD;
    else if (!cur_mode_i[B_NARROW])
      slot = SLOT_LOW_WIDE;
    else
      slot = SLOT_LOW_NARROW;
  end

  assign offset_o = {slot, kind_i, {SLOT_SHIFT{1'b0}}};
endmodule

// File: rtl/exc_psr_build.sv
module exc_psr_build
  import exc_entry_pkg::*;
(
  input  logic [PSR_W-1:0]  old_psr_i,
  input  logic [XLEN-1:0]   sysctl_i,
  input  logic              tag_en_i,
  input  logic [MODE_W-1:0] tgt_mode_i,
  output logic [PSR_W-1:0]  new_psr_o
);
  localparam int NKEEP = 5;
  localparam int KEEP_IDX [NKEEP] = '{B_N, B_Z, B_C, B_V, B_DIT};
  localparam int NSET = 4;
  localparam int SET_IDX [NSET] = '{B_DBG, B_SERRM, B_IRQM, B_FIQM};

  logic [PSR_W-1:0] keep_part;
  logic [PSR_W-1:0] set_part;
  logic [PSR_W-1:0] ctl_part;
  logic unused_sysctl;

  assign unused_sysctl = ^{sysctl_i[XLEN-1:SC_DSSBS+1], sysctl_i[SC_DSSBS-1:SC_SPAN+1],
                           sysctl_i[SC_SPAN-1:0]};

  for (genvar k = 0; k < PSR_W; k++) begin : g_bit
    logic kept, forced;
    always_comb begin
      kept = 1'b0;
      for (int j = 0; j < NKEEP; j++)
        if (KEEP_IDX[j] == k) kept = old_psr_i[k];
      forced = 1'b0;
      for (int j = 0; j < NSET; j++)
        if (SET_IDX[j] == k) forced = 1'b1;
    end
    assign keep_part[k] = kept;
    assign set_part[k]  = forced;
  end

  always_comb begin
    ctl_part = '0;
    ctl_part[B_TCO]  = tag_en_i;
    ctl_part[B_PAN]  = old_psr_i[B_PAN] | ~sysctl_i[SC_SPAN];
    ctl_part[B_SSBS] = sysctl_i[SC_DSSBS];
    ctl_part[MODE_W-1:0] = tgt_mode_i;
  end

  assign new_psr_o = keep_part | set_part | ctl_part;
endmodule

// File: rtl/exc_level_bank.sv
module exc_level_bank
  import exc_entry_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [XLEN-1:0]  link_d_i,
  input  logic [PSR_W-1:0] saved_d_i,
  output logic [XLEN-1:0]  link_q_o,
  output logic [PSR_W-1:0] saved_q_o
);
  logic [XLEN-1:0]  link_nxt;
  logic [PSR_W-1:0] saved_nxt;

  always_comb begin
    link_nxt  = link_q_o;
    saved_nxt = saved_q_o;
    if (wr_en_i) begin
      link_nxt  = link_d_i;
      saved_nxt = saved_d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q_o  <= '0;
      saved_q_o <= '0;
    end else begin
      link_q_o  <= link_nxt;
      saved_q_o <= saved_nxt;
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       exc_kind_i,
  input  logic [4:0]       tgt_mode_i,
  input  logic [63:0]      cur_pc_i,
  input  logic [31:0]      cur_psr_i,
  input  logic [63:0]      vbase_i,
  input  logic [63:0]      sysctl_i,
  input  logic             tag_en_i,
  output logic             done_o,
  output logic             err_o,
  output logic [63:0]      pc_o,
  output logic [31:0]      psr_o,
  output logic [63:0]      elr1_o,
  output logic [31:0]      spsr1_o,
  output logic [63:0]      elr2_o,
  output logic [31:0]      spsr2_o
);
  localparam int NLEV = 2;

  logic [OFS_W-1:0] vec_ofs;
  logic [PSR_W-1:0] psr_new;
  logic             tgt_ok;
  logic             take;
  logic [NLEV-1:0]  lev_we;
  logic [XLEN-1:0]  pc_nxt;
  logic [PSR_W-1:0] psr_nxt;
  logic             done_nxt, err_nxt;
  logic [XLEN-1:0]  pc_q;
  logic [PSR_W-1:0] psr_q;
  logic             done_q, err_q;
  logic [XLEN-1:0]  link_q  [NLEV];
  logic [PSR_W-1:0] saved_q [NLEV];

  exc_vec_sel u_vec (
    .cur_mode_i (cur_psr_i[MODE_W-1:0]),
    .tgt_mode_i (tgt_mode_i),
    .kind_i     (exc_kind_i),
    .offset_o   (vec_ofs)
  );

  exc_psr_build u_psr (
    .old_psr_i  (cur_psr_i),
    .sysctl_i   (sysctl_i),
    .tag_en_i   (tag_en_i),
    .tgt_mode_i (tgt_mode_i),
    .new_psr_o  (psr_new)
  );

  assign tgt_ok = (tgt_mode_i == MODE_LV1_H) || (tgt_mode_i == MODE_LV2_H);
  assign take   = start_i && tgt_ok;
  assign lev_we[0] = take && (tgt_mode_i == MODE_LV1_H);
  assign lev_we[1] = take && (tgt_mode_i == MODE_LV2_H);

  for (genvar lv = 0; lv < NLEV; lv++) begin : g_lev
    exc_level_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (lev_we[lv]),
      .link_d_i  (cur_pc_i),
      .saved_d_i (cur_psr_i),
      .link_q_o  (link_q[lv]),
      .saved_q_o (saved_q[lv])
    );
  end

  always_comb begin
    pc_nxt   = pc_q;
    psr_nxt  = psr_q;
    if (take) begin
      pc_nxt  = vbase_i + {{(XLEN-OFS_W){1'b0}}, vec_ofs};
      psr_nxt = psr_new;
    end
    done_nxt = start_i;
    err_nxt  = start_i && !tgt_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      psr_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pc_q   <= pc_nxt;
      psr_q  <= psr_nxt;
      done_q <= done_nxt;
      err_q  <= err_nxt;
    end
  end

  assign done_o  = done_q;
  assign err_o   = err_q;
  assign pc_o    = pc_q;
  assign psr_o   = psr_q;
  assign elr1_o  = link_q[0];
  assign spsr1_o = saved_q[0];
  assign elr2_o  = link_q[1];
  assign spsr2_o = saved_q[1];

  // R10
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  // R10
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);
  // R9
  illegal_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !tgt_ok) |=> (err_o && $stable(pc_o) && $stable(psr_o)
                              && $stable(elr1_o) && $stable(elr2_o)));
  // R8
  lv1_link_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && tgt_mode_i == MODE_LV1_H) |=> (elr1_o == $past(cur_pc_i)
                                              && spsr1_o == $past(cur_psr_i) && $stable(elr2_o)));
  // R7
  masks_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (psr_o[B_DBG:B_FIQM] == 4'hF));
  // R3
  pc_in_base_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && tgt_ok) |=> (pc_o - $past(vbase_i)) < 64'h800);
endmodule

// File: tb/exc_entry_unit_test.sv
module exc_entry_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  exc_kind_i = '0;
  logic [4:0]  tgt_mode_i = '0;
  logic [63:0] cur_pc_i = '0;
  logic [31:0] cur_psr_i = '0;
  logic [63:0] vbase_i = '0;
  logic [63:0] sysctl_i = '0;
  logic        tag_en_i = 1'b0;
  logic        done_o, err_o;
  logic [63:0] pc_o, elr1_o, elr2_o;
  logic [31:0] psr_o, spsr1_o, spsr2_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [63:0] m_pc, m_elr1, m_elr2;
  logic [31:0] m_psr, m_spsr1, m_spsr2;

  always #2 clk = ~clk;

  exc_entry_unit uut (.*);

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [63:0] ref_ofs(input logic [4:0] cm, input logic [4:0] tg, input logic [1:0] k);
    logic [63:0] base;
    if (cm == tg) base = 64'h200;
    else if ((cm | 5'd1) == tg) base = 64'h000;
    else if (cm[4] == 1'b0) base = 64'h400;
    else base = 64'h600;
    return base + 64'(k) * 64'h80;
  endfunction

  function automatic logic [31:0] ref_psr(input logic [31:0] o, input logic [63:0] sc,
                                          input logic tag, input logic [4:0] tg);
    logic [31:0] e = '0;
    e[31:28] = o[31:28];
    e[24] = o[24];
    e[25] = tag;
    e[22] = o[22] | ~sc[23];
    e[12] = sc[44];
    e[9:6] = 4'hF;
    e[4:0] = tg;
    return e;
  endfunction

  task automatic check_state(input string req);
    chk(req, "pc", pc_o, m_pc);
    chk(req, "psr", {32'h0, psr_o}, {32'h0, m_psr});
    chk("R8", "elr1", elr1_o, m_elr1);
    chk("R8", "spsr1", {32'h0, spsr1_o}, {32'h0, m_spsr1});
    chk("R8", "elr2", elr2_o, m_elr2);
    chk("R8", "spsr2", {32'h0, spsr2_o}, {32'h0, m_spsr2});
  endtask

  task automatic run_one(input logic [4:0] cm, input logic [4:0] tg, input logic [1:0] k);
    logic legal;
    @(negedge clk);
    cur_psr_i  = {$urandom(), 5'b0} | {27'b0, cm};
    cur_pc_i   = {$urandom(), $urandom()};
    vbase_i    = {$urandom(), $urandom()};
    sysctl_i   = {$urandom(), $urandom()};
    tag_en_i   = $urandom() & 1;
    tgt_mode_i = tg;
    exc_kind_i = k;
    start_i    = 1'b1;
    legal = (tg == 5'h05) || (tg == 5'h09);
    if (legal) begin
      m_pc  = vbase_i + ref_ofs(cm, tg, k);
      m_psr = ref_psr(cur_psr_i, sysctl_i, tag_en_i, tg);
      if (tg == 5'h05) begin m_elr1 = cur_pc_i; m_spsr1 = cur_psr_i; end
      else begin m_elr2 = cur_pc_i; m_spsr2 = cur_psr_i; end
    end
    @(negedge clk);
    start_i = 1'b0;
    chk("R10", "done after start", {63'h0, done_o}, 64'd1);
    chk(legal ? "R3" : "R9", "err", {63'h0, err_o}, {63'h0, !legal});
    // R2 R4 R5 R6 R7 via psr/pc compare; R9 when illegal (model unchanged)
    check_state(legal ? "R2/R3 R4 R5 R6 R7" : "R9");
    @(negedge clk);
    chk("R10", "done one cycle", {63'h0, done_o}, 64'd0);
  endtask

  initial begin
    m_pc = '0; m_elr1 = '0; m_elr2 = '0; m_psr = '0; m_spsr1 = '0; m_spsr2 = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check_state("R1");
    chk("R1", "done", {63'h0, done_o}, 64'd0);
    chk("R1", "err", {63'h0, err_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");
    for (int tsel = 0; tsel < 6; tsel++) begin
      logic [4:0] tg;
      case (tsel)
        0: tg = 5'h05;
        1: tg = 5'h09;
        2: tg = 5'h04;
        3: tg = 5'h0D;
        4: tg = 5'h15;
        default: tg = 5'h00;
      endcase
      for (int cm = 0; cm < 32; cm++)
        for (int k = 0; k < 4; k++)
          run_one(5'(cm), tg, 2'(k));
    end
    // R10: no done without start over idle cycles
    repeat (4) begin
      @(negedge clk);
      chk("R10", "idle done", {63'h0, done_o}, 64'd0);
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule